// File: doc/BRIEF.md
# Flash Dual-Map Redirect Decoder

This block sits beside the on-chip flash array and decides, access by access, whether a bus access that falls into the flash address window is served by the internal array or handed to the external memory controller. One region can be set up for redirection. The region is described by an address base with an address mask, a cycle-type value with a type mask, and an enable bit. An access hits the region when the block is enabled, the address lies in the flash window, every address bit selected by the mask equals the base, and every type bit selected by the type mask equals the programmed type.

On a hit the flash-respond output stays low and the external-claim output goes high, so the external controller runs the access. On a miss inside the flash window the flash array responds. Accesses outside the flash window leave both outputs low. An access may last several cycles. The decision is taken on its first cycle and held until its last cycle, so a configuration write made while an access is running only affects later accesses. Configuration is loaded through a small write-only port with a two-bit register select.

Top module: `fmap_redirect`

## Requirements
- R1: After reset the enable bit and all programmed fields are zero, so no access is redirected. Both outputs are low while `acc_valid` is low.
- R2: While the enable bit is clear, every valid access inside the flash window gives `flash_resp`=1 and `ext_claim`=0.
- R3: Address matching compares only the address bits where the address mask (select 1) is 1. The base is loaded through select 0. Bits where the mask is 0 are ignored.
- R4: Cycle-type matching compares only the bits where the type mask is 1. The type value sits at control word bits [12:8] and the type mask at bits [20:16].
- R5: On a hit (enabled, in the flash window, address match and type match) the outputs are `ext_claim`=1 and `flash_resp`=0 in the same cycle as the access.
- R6: A valid access whose upper address bits [31:20] differ from the flash window base (zero by default) gives `flash_resp`=0 and `ext_claim`=0.
- R7: `flash_resp` and `ext_claim` are never high together, and both are low when `acc_valid` is low.
- R8: A write to select 0, 1 or 2 takes effect from the clock edge that captures it. The enable bit is control word bit 0. An access whose first cycle is the cycle of the write still uses the old values. Select 3 changes nothing.
- R9: An access runs from its first valid cycle to the cycle where `acc_last` is high, or until `acc_valid` drops. Its decision is held for that whole span, even if the address, the type or the configuration changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 address mask, 2 control, 3 none |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Access valid, held high for every cycle of an access |
| acc_last | input | 1 | Marks the final cycle of an access |
| acc_addr | input | 32 | Access address |
| acc_type | input | 5 | Access cycle type |
| flash_resp | output | 1 | Internal flash array serves this access |
| ext_claim | output | 1 | External memory controller takes this access |

## Verification
The decoder is driven with addresses that differ from the base only in masked-off bits and with addresses that differ in a compared bit. This separates a correct masked compare from a full compare and from no compare. Cycle types are varied in the same way, both in the don't-care bit and in compared bits. Addresses outside the flash window show that the window check is separate from the region match. Multi-cycle accesses have their address and the configuration changed partway through. Configuration writes are placed in the same cycle as an access start. Together these show that the decision is taken once per access and that the new registers take effect at the following edge.

// File: rtl/fmap_pkg.sv
package fmap_pkg;

  // register select codes for the configuration port
  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  // control word field positions
  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_TYPE_LSB  = 8;
  localparam int CTRL_TMASK_LSB = 16;

  // live decision for the current access
  typedef struct packed {
    logic in_win;
    logic hit;
  } decision_t;

  // equality of two words restricted to the bits set in a mask
  function automatic logic masked_equal(input logic [31:0] a,
                                        input logic [31:0] b,
                                        input logic [31:0] m);
    return ((a ^ b) & m) == 32'd0;
  endfunction

  // bits of the control word that carry meaning
  function automatic logic [31:0] ctrl_used_bits(input int type_w);
    logic [31:0] u;
    u = 32'd0;
    u[CTRL_EN_BIT] = 1'b1;
    for (int i = 0; i < type_w; i++) begin
      u[CTRL_TYPE_LSB + i]  = 1'b1;
      u[CTRL_TMASK_LSB + i] = 1'b1;
    end
    return u;
  endfunction

endpackage

// File: rtl/fmap_cfg_regs.sv
module fmap_cfg_regs
  import fmap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TYPE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] mask_q,
  output logic              en_q,
  output logic [TYPE_W-1:0] tfield_q,
  output logic [TYPE_W-1:0] tmask_q
);

  localparam logic [31:0] USED = ctrl_used_bits(TYPE_W);

  // named write events
  logic wr_base, wr_mask, wr_ctrl;
  assign wr_base = wr && (cfg_sel_e'(sel) == SEL_BASE);
  assign wr_mask = wr && (cfg_sel_e'(sel) == SEL_MASK);
  assign wr_ctrl = wr && (cfg_sel_e'(sel) == SEL_CTRL);

  logic cfg_unused_bits;
  assign cfg_unused_bits = ^(32'(wdata) & ~USED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      mask_q   <= '0;
      en_q     <= 1'b0;
      tfield_q <= '0;
      tmask_q  <= '0;
    end else begin
      if (wr_base) base_q <= wdata;
      if (wr_mask) mask_q <= wdata;
      if (wr_ctrl) begin
        en_q     <= wdata[CTRL_EN_BIT];
        tfield_q <= wdata[CTRL_TYPE_LSB +: TYPE_W];
        tmask_q  <= wdata[CTRL_TMASK_LSB +: TYPE_W];
      end
    end
  end

  // R8: a captured write lands at the following edge
  p_base_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_base |=> base_q == $past(wdata));
  p_ctrl_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> en_q == $past(wdata[CTRL_EN_BIT]));
  // R8: select 3 leaves every register untouched
  p_none_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == 2'd3) |=> ($stable(base_q) && $stable(mask_q) && $stable(en_q)));

endmodule

// File: rtl/fmap_match.sv
module fmap_match
  import fmap_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          TYPE_W     = 5,
  parameter int          FLASH_AW   = 20,
  parameter logic [31:0] FLASH_BASE = 32'h0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [TYPE_W-1:0] atype,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  input  logic              en,
  input  logic [TYPE_W-1:0] tfield,
  input  logic [TYPE_W-1:0] tmask,
  output decision_t         dec
);

  localparam int HI_W = ADDR_W - FLASH_AW;

  // per-bit compare vectors, one lane per bit
  logic [ADDR_W-1:0] addr_bit_ok;
  logic [TYPE_W-1:0] type_bit_ok;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_abit
    assign addr_bit_ok[i] = !mask[i] || (addr[i] == base[i]);
  end
  for (genvar j = 0; j < TYPE_W; j++) begin : g_tbit
    assign type_bit_ok[j] = !tmask[j] || (atype[j] == tfield[j]);
  end

  logic addr_ok, type_ok, in_win;
  assign addr_ok = &addr_bit_ok;
  assign type_ok = &type_bit_ok;
  assign in_win  = addr[ADDR_W-1:FLASH_AW] == FLASH_BASE[ADDR_W-1:FLASH_AW];

  assign dec.in_win = in_win;
  assign dec.hit    = en && in_win && addr_ok && type_ok;

  // lane vectors agree with the word-wide form in the package
  always_comb begin
    p_addr_lanes_r3: assert (addr_ok == masked_equal(32'(addr), 32'(base), 32'(mask)));
    p_type_lanes_r4: assert (type_ok == masked_equal(32'(atype), 32'(tfield), 32'(tmask)));
  end

  logic [HI_W-1:0] hi_unused;
  assign hi_unused = '0;

endmodule

// File: rtl/fmap_hold.sv
module fmap_hold
  import fmap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      acc_valid,
  input  logic      acc_last,
  input  decision_t live,
  output decision_t use_dec,
  output logic      busy
);

  decision_t held;
  logic      start_multi;

  // first cycle of an access that continues past this edge
  assign start_multi = acc_valid && !busy && !acc_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      held <= '0;
    end else if (start_multi) begin
      busy <= 1'b1;
      held <= live;
    end else if (busy && (!acc_valid || acc_last)) begin
      busy <= 1'b0;
    end
  end

  assign use_dec = busy ? held : live;

  // R9: decision is frozen while an access continues
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && acc_valid) |-> (use_dec == $past(use_dec)));
  p_hold_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_multi |=> busy);

endmodule

// File: rtl/fmap_redirect.sv
module fmap_redirect
  import fmap_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          TYPE_W     = 5,
  parameter int          FLASH_AW   = 20,
  parameter logic [31:0] FLASH_BASE = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              acc_valid,
  input  logic              acc_last,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [TYPE_W-1:0] acc_type,
  output logic              flash_resp,
  output logic              ext_claim
);

  logic [ADDR_W-1:0] base_q, mask_q;
  logic              en_q;
  logic [TYPE_W-1:0] tfield_q, tmask_q;
  decision_t         live_dec, use_dec;
  logic              busy;

  fmap_cfg_regs #(.ADDR_W(ADDR_W), .TYPE_W(TYPE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
    .base_q(base_q), .mask_q(mask_q), .en_q(en_q),
    .tfield_q(tfield_q), .tmask_q(tmask_q)
  );

  fmap_match #(.ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .FLASH_AW(FLASH_AW),
               .FLASH_BASE(FLASH_BASE)) u_match (
    .addr(acc_addr), .atype(acc_type), .base(base_q), .mask(mask_q),
    .en(en_q), .tfield(tfield_q), .tmask(tmask_q), .dec(live_dec)
  );

  fmap_hold u_hold (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_last(acc_last),
    .live(live_dec), .use_dec(use_dec), .busy(busy)
  );

  assign ext_claim  = acc_valid && use_dec.hit;
  assign flash_resp = acc_valid && use_dec.in_win && !use_dec.hit;

  // R7: the two outputs never overlap and are quiet when idle
  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(flash_resp && ext_claim));
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!flash_resp && !ext_claim));
  // R2: a fresh access while disabled is never claimed
  p_no_claim_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !busy && !en_q) |-> !ext_claim);
  // R6: a fresh access outside the window draws no response
  p_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !busy && !live_dec.in_win) |-> (!flash_resp && !ext_claim));
  // R5: a fresh in-window access is always answered by exactly one side
  p_one_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !busy && live_dec.in_win) |-> (flash_resp != ext_claim));

endmodule

// File: tb/sim_fmap_redirect.sv
module sim_fmap_redirect;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        acc_valid = 1'b0;
  logic        acc_last = 1'b0;
  logic [31:0] acc_addr = 32'd0;
  logic [4:0]  acc_type = 5'd0;
  logic        flash_resp, ext_claim;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fmap_redirect u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_last(acc_last),
    .acc_addr(acc_addr), .acc_type(acc_type),
    .flash_resp(flash_resp), .ext_claim(ext_claim)
  );

  // region under test: 256 KiB at 0x0004_0000, type 0b0001x
  localparam logic [31:0] RBASE = 32'h0004_0000;
  localparam logic [31:0] RMASK = 32'hFFFC_0000;
  localparam logic [31:0] CTRL_ON  = 32'h001E_0201; // en=1, type=00010, tmask=11110
  localparam logic [31:0] CTRL_OFF = 32'h001E_0200;

  task automatic check(input string tag, input logic ef, input logic ee);
    n_chk++;
    if (flash_resp !== ef || ext_claim !== ee) begin
      n_fail++;
      $display("FAIL %s: flash_resp/ext_claim = %b%b expected %b%b",
               tag, flash_resp, ext_claim, ef, ee);
    end
  endtask

  task automatic write_cfg(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // single-cycle access, checked in its own cycle
  task automatic one_access(input logic [31:0] a, input logic [4:0] t,
                            input logic ef, input logic ee, input string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_last = 1'b1; acc_addr = a; acc_type = t;
    #2 check(tag, ef, ee);
    @(negedge clk);
    acc_valid = 1'b0; acc_last = 1'b0;
  endtask

  task automatic t_reset;
    #2 check("R1 idle in reset", 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    one_access(RBASE, 5'b00010, 1'b1, 1'b0, "R1 nothing redirected after reset");
    #1 check("R7 idle after access", 1'b0, 1'b0);
  endtask

  task automatic t_disabled;
    write_cfg(2'd0, RBASE);
    write_cfg(2'd1, RMASK);
    write_cfg(2'd2, CTRL_OFF);
    one_access(RBASE + 32'h10, 5'b00010, 1'b1, 1'b0, "R2 disabled gives flash");
  endtask

  task automatic t_addr_mask;
    write_cfg(2'd2, CTRL_ON);
    one_access(RBASE + 32'h3_FFFC, 5'b00010, 1'b0, 1'b1, "R3 masked-off low bits ignored");
    one_access(32'h0008_0000, 5'b00010, 1'b1, 1'b0, "R3 compared bit differs");
    one_access(32'h0000_1000, 5'b00010, 1'b1, 1'b0, "R3 below region");
    one_access(RBASE, 5'b00010, 1'b0, 1'b1, "R5 hit claims external");
  endtask

  task automatic t_type_mask;
    one_access(RBASE, 5'b00011, 1'b0, 1'b1, "R4 don't-care type bit");
    one_access(RBASE, 5'b00110, 1'b1, 1'b0, "R4 compared type bit differs");
    one_access(RBASE, 5'b10010, 1'b1, 1'b0, "R4 top type bit differs");
  endtask

  task automatic t_window;
    one_access(32'h0010_0000, 5'b00010, 1'b0, 1'b0, "R6 just past window");
    write_cfg(2'd1, 32'h0);
    one_access(32'h8004_0000, 5'b00010, 1'b0, 1'b0, "R6 outside window with open mask");
    one_access(32'h000F_0000, 5'b00010, 1'b0, 1'b1, "R3 zero mask matches all in window");
    write_cfg(2'd1, RMASK);
  endtask

  task automatic t_write_timing;
    // write disable in the same cycle as an access start
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 2'd2; cfg_wdata = CTRL_OFF;
    acc_valid = 1'b1; acc_last = 1'b1; acc_addr = RBASE; acc_type = 5'b00010;
    #2 check("R8 write not yet visible", 1'b0, 1'b1);
    @(negedge clk);
    cfg_wr = 1'b0;
    #2 check("R8 write visible next access", 1'b1, 1'b0);
    @(negedge clk);
    acc_valid = 1'b0; acc_last = 1'b0;
    // select 3 must not touch anything
    write_cfg(2'd3, 32'hFFFF_FFFF);
    one_access(RBASE, 5'b00010, 1'b1, 1'b0, "R8 select 3 ignored");
    write_cfg(2'd2, CTRL_ON);
  endtask

  task automatic t_hold;
    @(negedge clk);
    acc_valid = 1'b1; acc_last = 1'b0; acc_addr = RBASE; acc_type = 5'b00010;
    #2 check("R9 first cycle hit", 1'b0, 1'b1);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 2'd2; cfg_wdata = CTRL_OFF;
    acc_addr = 32'h0008_0000;
    #2 check("R9 held despite address change", 1'b0, 1'b1);
    @(negedge clk);
    cfg_wr = 1'b0; acc_last = 1'b1;
    #2 check("R9 held despite config write", 1'b0, 1'b1);
    @(negedge clk);
    acc_valid = 1'b0; acc_last = 1'b0;
    #2 check("R7 quiet between accesses", 1'b0, 1'b0);
    one_access(RBASE, 5'b00010, 1'b1, 1'b0, "R9 next access uses new config");
    // miss held while the region is re-enabled
    @(negedge clk);
    acc_valid = 1'b1; acc_last = 1'b0; acc_addr = RBASE;
    cfg_wr = 1'b1; cfg_sel = 2'd2; cfg_wdata = CTRL_ON;
    #2 check("R9 miss start", 1'b1, 1'b0);
    @(negedge clk);
    cfg_wr = 1'b0;
    #2 check("R9 miss held after enable", 1'b1, 1'b0);
    @(negedge clk);
    acc_valid = 1'b0;
    one_access(RBASE, 5'b00010, 1'b0, 1'b1, "R9 valid drop ends access");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_disabled();
    t_addr_mask();
    t_type_mask();
    t_window();
    t_write_timing();
    t_hold();
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule